// File: doc/BRIEF.md
# Converter Control and Result Register Block

This block is the digital front end of a successive-approximation analog-to-digital converter. It sits on a simple byte-wide CPU register bus and gives software three registers: a control/status byte, and a low and a high result byte. From the control byte it derives a converter clock strobe by dividing the system clock. It launches conversions through a request channel to the converter core and accepts 10-bit results on a response channel. It stores each accepted result as a byte pair, sets a completion flag and raises an interrupt request when enabled.

A conversion runs once per start command, or back to back while the continuous bit is set. Clearing the enable bit aborts any conversion in flight. Reading the low result byte freezes the pair until the high byte is read, so software never combines bytes from two different results. Results that arrive during the freeze are dropped.

Both converter channels use valid/ready. `req_valid` rises one cycle after a start and stays high until `req_ready` is seen, unless enable is cleared. `rsp_ready` is high exactly while a conversion is outstanding. A response offered at any other time is never taken.

Top module: `convctl_top`

## Requirements
- R1: After reset the control byte, both result bytes, `irq`, `req_valid`, `rsp_ready` and `conv_tick` are all 0.
- R2: The control byte at address 0 is laid out as bit 7 enable, bit 6 start, bit 5 continuous, bit 4 flag, bit 3 interrupt enable, bits 2..0 divider code. Writing bit 6 = 1 together with bit 7 = 1 while idle raises `req_valid` on the next cycle. Bit 6 reads 1 from then until the conversion completes. A start written with bit 7 = 0 does nothing. `req_valid` holds until `req_ready`, and `rsp_ready` is never high together with `req_valid`.
- R3: An accepted result drives address 1 (low byte) with result bits 7..0 and address 2 (high byte) with result bits 9..8 in bits 1..0; the other high-byte bits read 0.
- R4: The flag (bit 4) is set on the same clock edge that updates the result bytes.
- R5: Writing the control byte with bit 4 = 1 clears the flag; bit 4 = 0 leaves it. This holds when the write puts back the value just read.
- R6: A one-cycle `irq_ack` clears the flag. When a result is accepted on the same edge as a clear, the flag ends up 1.
- R7: `irq` is 1 exactly when the flag, the interrupt enable bit and `gie` are all 1.
- R8: With the continuous bit set, a completed conversion is followed at once by a new request. If the bit is cleared, the conversion in flight is the last one.
- R9: While enabled, `conv_tick` pulses once every D system cycles. D is 2, 2, 4, 8, 16, 32, 64 or 128 for divider codes 0 to 7.
- R10: Reading address 1 locks the result pair, and reading address 2 unlocks it. A result accepted while locked, or on the edge of the low-byte read, is discarded: the bytes stay unchanged and the flag is not set.
- R11: Writing enable = 0 drops `req_valid` and `rsp_ready` on the next edge and clears the start bit. It also stops `conv_tick`. The result bytes are left as they were, and a late response is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (read side effects) |
| bus_addr | input | 2 | Register address: 0 control, 1 low, 2 high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| gie | input | 1 | Global interrupt enable from the CPU |
| irq | output | 1 | Conversion-complete interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge for this vector |
| conv_tick | output | 1 | Converter clock strobe from the divider |
| req_valid | output | 1 | Conversion request to the core |
| req_ready | input | 1 | Core accepts the request |
| rsp_valid | input | 1 | Core offers a result |
| rsp_ready | output | 1 | Block can take a result |
| rsp_data | input | 10 | Conversion result |

## Verification
Two sets of events can land on one clock edge. A result can be accepted in the same cycle that software or the interrupt controller clears the flag. A low-byte read can also coincide with an arriving result. The bench provokes the first by driving a flag-clearing write in the exact cycle the response handshake completes, and expects the flag to end up 1 with the new result stored. For the second, the bench locks the pair before a result arrives, in random order across many iterations. It then judges the readback against a bench-side model that holds the previously stored value and expects the flag to stay 0.

// File: rtl/convctl_pkg.sv
package convctl_pkg;

  // Control byte bit positions (software-visible layout)
  localparam int CSR_EN_B    = 7;
  localparam int CSR_GO_B    = 6;
  localparam int CSR_CONT_B  = 5;
  localparam int CSR_FLAG_B  = 4;
  localparam int CSR_IE_B    = 3;
  localparam int CSR_PS_W    = 3;

  // Register addresses
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LO   = 2'd1;
  localparam logic [1:0] ADDR_HI   = 2'd2;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic                 en;
    logic                 cont;
    logic                 ie;
    logic [CSR_PS_W-1:0]  ps;
  } ctrl_t;

endpackage

// File: rtl/convctl_prescaler.sv
module convctl_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] code,
  output logic            tick
);
  localparam int MAX_SHIFT = (1 << PS_W) - 1;
  localparam int CNT_W     = MAX_SHIFT;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   pow2;
  logic [CNT_W-1:0] lim;

  // Division factor is 2^code, except code 0 which also divides by 2
  always_comb begin
    pow2 = {{CNT_W{1'b0}}, 1'b1} << code;
    if (code == '0) lim = CNT_W'(1);
    else            lim = CNT_W'(pow2 - 1'b1);
  end

  assign tick = run && (cnt_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/convctl_seq.sv
module convctl_seq
  import convctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_nxt,
  input  logic cont_nxt,
  input  logic go,
  input  logic req_ready,
  input  logic rsp_valid,
  output logic req_valid,
  output logic rsp_ready,
  output logic busy,
  output logic done
);
  seq_state_e st_q, st_d;

  assign req_valid = (st_q == SQ_REQ);
  assign rsp_ready = (st_q == SQ_WAIT);
  assign busy      = (st_q != SQ_IDLE);
  assign done      = rsp_ready && rsp_valid && en_nxt;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE: if (go)        st_d = SQ_REQ;
      SQ_REQ:  if (req_ready) st_d = SQ_WAIT;
      SQ_WAIT: if (rsp_valid) st_d = cont_nxt ? SQ_REQ : SQ_IDLE;
      default:                st_d = SQ_IDLE;
    endcase
    if (!en_nxt) st_d = SQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/convctl_result.sv
module convctl_result #(
  parameter int RES_W  = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [RES_W-1:0]  res,
  input  logic              rd_lo,
  input  logic              rd_hi,
  output logic [DATA_W-1:0] lo,
  output logic [DATA_W-1:0] hi,
  output logic              locked,
  output logic              accepted
);
  localparam int PAD_W = 2 * DATA_W - RES_W;

  logic lock_q;

  assign locked   = lock_q;
  // A low-byte read on the update edge also blocks the update (no tearing)
  assign accepted = upd && !lock_q && !rd_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else if (accepted) begin
      lo <= res[DATA_W-1:0];
      hi <= {{PAD_W{1'b0}}, res[RES_W-1:DATA_W]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lock_q <= 1'b0;
    else if (rd_lo) lock_q <= 1'b1;
    else if (rd_hi) lock_q <= 1'b0;
  end
endmodule

// File: rtl/convctl_top.sv
module convctl_top
  import convctl_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              gie,
  output logic              irq,
  input  logic              irq_ack,
  output logic              conv_tick,
  output logic              req_valid,
  input  logic              req_ready,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [RES_W-1:0]  rsp_data
);
  ctrl_t             ctrl_q;
  logic              flag_q;
  logic              wr_ctrl, rd_lo, rd_hi;
  logic              en_nxt, cont_nxt, go, flag_clr;
  logic              busy, done, accepted, res_locked;
  logic [DATA_W-1:0] res_lo, res_hi;

  assign wr_ctrl  = bus_sel && bus_wr && (bus_addr == ADDR_CTRL);
  assign rd_lo    = bus_sel && bus_rd && (bus_addr == ADDR_LO);
  assign rd_hi    = bus_sel && bus_rd && (bus_addr == ADDR_HI);

  assign en_nxt   = wr_ctrl ? bus_wdata[CSR_EN_B]   : ctrl_q.en;
  assign cont_nxt = wr_ctrl ? bus_wdata[CSR_CONT_B] : ctrl_q.cont;
  assign go       = wr_ctrl && bus_wdata[CSR_GO_B] && bus_wdata[CSR_EN_B];
  assign flag_clr = (wr_ctrl && bus_wdata[CSR_FLAG_B]) || irq_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.en   <= bus_wdata[CSR_EN_B];
      ctrl_q.cont <= bus_wdata[CSR_CONT_B];
      ctrl_q.ie   <= bus_wdata[CSR_IE_B];
      ctrl_q.ps   <= bus_wdata[CSR_PS_W-1:0];
    end
  end

  // Set beats clear when both land on one edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (accepted) flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign irq = flag_q && ctrl_q.ie && gie;

  convctl_prescaler #(.PS_W(CSR_PS_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (ctrl_q.en),
    .code (ctrl_q.ps),
    .tick (conv_tick)
  );

  convctl_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_nxt   (en_nxt),
    .cont_nxt (cont_nxt),
    .go       (go),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .req_valid(req_valid),
    .rsp_ready(rsp_ready),
    .busy     (busy),
    .done     (done)
  );

  convctl_result #(.RES_W(RES_W), .DATA_W(DATA_W)) u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (done),
    .res     (rsp_data),
    .rd_lo   (rd_lo),
    .rd_hi   (rd_hi),
    .lo      (res_lo),
    .hi      (res_hi),
    .locked  (res_locked),
    .accepted(accepted)
  );

  always_comb begin
    unique case (bus_addr)
      ADDR_CTRL: bus_rdata = {ctrl_q.en, busy, ctrl_q.cont, flag_q, ctrl_q.ie, ctrl_q.ps};
      ADDR_LO:   bus_rdata = res_lo;
      ADDR_HI:   bus_rdata = res_hi;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/convctl_chk.sv
module convctl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              gie,
  input logic              ie,
  input logic              flag,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_ready,
  input logic              en_q,
  input logic              en_nxt,
  input logic              tick,
  input logic              locked,
  input logic              accepted,
  input logic [DATA_W-1:0] res_lo,
  input logic [DATA_W-1:0] res_hi
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && en_nxt) |=> req_valid); // R2

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready)); // R2

  AST_FLAG_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |=> flag); // R4

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (gie && ie)); // R7

  AST_FROZEN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(res_lo) && $stable(res_hi))); // R10

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!req_valid && !rsp_ready && !tick)); // R11
endmodule

bind convctl_top convctl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq),
  .gie      (gie),
  .ie       (ctrl_q.ie),
  .flag     (flag_q),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_ready(rsp_ready),
  .en_q     (ctrl_q.en),
  .en_nxt   (en_nxt),
  .tick     (conv_tick),
  .locked   (res_locked),
  .accepted (accepted),
  .res_lo   (res_lo),
  .res_hi   (res_hi)
);

// File: tb/convctl_top_tb_top.sv
`timescale 1ns/1ps
module convctl_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       gie = 0, irq, irq_ack = 0, conv_tick;
  logic       req_valid, req_ready = 0, rsp_valid = 0, rsp_ready;
  logic [9:0] rsp_data = 0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  convctl_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gie(gie), .irq(irq), .irq_ack(irq_ack), .conv_tick(conv_tick),
    .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  function automatic logic [7:0] e_lo(logic [9:0] v); return v[7:0]; endfunction
  function automatic logic [7:0] e_hi(logic [9:0] v); return {6'b0, v[9:8]}; endfunction
  function automatic int e_div(int code); return (code == 0) ? 2 : (1 << code); endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [7:0] d);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
  endtask

  task automatic req_handshake();
    int n;
    n = 0;
    while (!req_valid && n < 50) begin @(negedge clk); n++; end
    repeat ($urandom_range(0, 2)) @(negedge clk);
    req_ready = 1; @(negedge clk); req_ready = 0;
  endtask

  task automatic convert(logic [9:0] v, int lat);
    req_handshake();
    repeat (lat) @(negedge clk);
    rsp_data = v; rsp_valid = 1; @(negedge clk); rsp_valid = 0;
  endtask

  task automatic read_pair(output logic [7:0] lo, output logic [7:0] hi);
    bus_read(2'd1, lo);
    bus_read(2'd2, hi);
  endtask

  logic [7:0] rd, lo, hi;
  logic [9:0] cur;

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0C0FFEE5));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    bus_read(2'd0, rd); check("R1 ctrl", rd, 0);
    read_pair(lo, hi);  check("R1 lo", lo, 0); check("R1 hi", hi, 0);
    check("R1 irq", irq, 0); check("R1 req", req_valid, 0);
    check("R1 rsp_ready", rsp_ready, 0); check("R1 tick", conv_tick, 0);

    // R2 start without enable is ignored
    bus_write(2'd0, 8'h40);
    check("R2 no-en req", req_valid, 0);
    bus_read(2'd0, rd); check("R2 no-en start bit", rd[6], 0);

    // R2 start with enable
    bus_write(2'd0, 8'hC8);
    check("R2 req raised", req_valid, 1);
    bus_read(2'd0, rd); check("R2 start reads 1", rd[6], 1);

    // R3 R4 single conversion
    convert(10'h2A5, 2);
    bus_read(2'd0, rd);
    check("R4 flag set", rd[4], 1); check("R2 start cleared", rd[6], 0);
    read_pair(lo, hi);
    check("R3 lo", lo, e_lo(10'h2A5)); check("R3 hi", hi, e_hi(10'h2A5));

    // R7 interrupt gating
    check("R7 gie off", irq, 0);
    gie = 1; #1 check("R7 all on", irq, 1);
    bus_write(2'd0, 8'h80); check("R7 ie off", irq, 0);
    bus_write(2'd0, 8'h88); check("R7 ie back", irq, 1);

    // R5 writing 0 keeps flag, read-modify-write clears it
    bus_read(2'd0, rd); check("R5 flag kept", rd[4], 1);
    bus_write(2'd0, rd);
    bus_read(2'd0, rd); check("R5 rmw clears", rd[4], 0);
    check("R7 flag off", irq, 0);

    // R6 acknowledge clears
    bus_write(2'd0, 8'hC8); convert(10'h011, 1);
    check("R6 irq before ack", irq, 1);
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    bus_read(2'd0, rd); check("R6 ack clears", rd[4], 0);
    check("R6 irq after ack", irq, 0);

    // R6 accept and clear on the same edge: set wins
    bus_write(2'd0, 8'hC8);
    req_handshake();
    rsp_data = 10'h0F0; rsp_valid = 1;
    bus_sel = 1; bus_wr = 1; bus_addr = 2'd0; bus_wdata = 8'h98;
    @(negedge clk);
    rsp_valid = 0; bus_sel = 0; bus_wr = 0;
    bus_read(2'd0, rd); check("R6 set beats clear", rd[4], 1);
    read_pair(lo, hi); check("R6 same-edge lo", lo, e_lo(10'h0F0));

    // R8 continuous mode
    bus_write(2'd0, 8'hF8);
    convert(10'h155, 2);
    check("R8 restart", req_valid, 1);
    read_pair(lo, hi);
    check("R8 lo", lo, e_lo(10'h155)); check("R8 hi", hi, e_hi(10'h155));
    bus_write(2'd0, 8'h88);
    convert(10'h1C3, 1);
    check("R8 stopped", req_valid, 0);
    bus_read(2'd0, rd); check("R8 start bit idle", rd[6], 0);
    read_pair(lo, hi); check("R8 last lo", lo, e_lo(10'h1C3));

    // R10 lock discards result
    bus_write(2'd0, 8'h98);
    bus_read(2'd1, lo);
    bus_write(2'd0, 8'hC8);
    convert(10'h3FF, 1);
    bus_read(2'd0, rd); check("R10 flag stays 0", rd[4], 0);
    bus_read(2'd2, hi); check("R10 hi kept", hi, e_hi(10'h1C3));
    read_pair(lo, hi);  check("R10 lo kept", lo, e_lo(10'h1C3));
    bus_write(2'd0, 8'hC8);
    convert(10'h2D2, 0);
    read_pair(lo, hi);  check("R10 unlocked update", lo, e_lo(10'h2D2));

    // R11 abort
    bus_write(2'd0, 8'hC8);
    req_handshake();
    bus_write(2'd0, 8'h08);
    check("R11 req low", req_valid, 0); check("R11 rsp_ready low", rsp_ready, 0);
    bus_read(2'd0, rd); check("R11 start cleared", rd[7:6], 0);
    rsp_data = 10'h001; rsp_valid = 1; @(negedge clk); rsp_valid = 0;
    read_pair(lo, hi);
    check("R11 lo kept", lo, e_lo(10'h2D2)); check("R11 hi kept", hi, e_hi(10'h2D2));
    begin
      int ticks;
      ticks = 0;
      for (int i = 0; i < 300; i++) begin if (conv_tick) ticks++; @(negedge clk); end
      check("R11 no ticks", ticks, 0);
    end

    // R9 divider codes
    for (int c = 0; c < 8; c++) begin
      int n, p;
      bus_write(2'd0, 8'h80 | 8'(c));
      n = 0;
      while (!conv_tick && n < 400) begin @(negedge clk); n++; end
      @(negedge clk);
      p = 1;
      while (!conv_tick && p < 400) begin @(negedge clk); p++; end
      check($sformatf("R9 code %0d", c), p, e_div(c));
    end

    // R3 R4 R10 random results, random lock
    cur = 10'h2D2;
    for (int it = 0; it < 40; it++) begin
      logic [9:0] v;
      bit lk;
      v  = 10'($urandom);
      lk = 1'($urandom);
      bus_write(2'd0, 8'h98);
      if (lk) bus_read(2'd1, lo);
      bus_write(2'd0, 8'hC8);
      convert(v, $urandom_range(0, 4));
      if (!lk) cur = v;
      bus_read(2'd0, rd); check(lk ? "R10 rnd flag" : "R4 rnd flag", rd[4], lk ? 0 : 1);
      if (lk) begin bus_read(2'd2, hi); check("R10 rnd hi", hi, e_hi(cur)); end
      read_pair(lo, hi);
      check("R3 rnd lo", lo, e_lo(cur)); check("R3 rnd hi", hi, e_hi(cur));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule